// File: doc/BRIEF.md
# Dual-Mode Successive-Approximation Converter Controller

This block holds the digital sequencing for one column converter. The converter runs in one of two quantization schemes. The first is a high-precision scheme with 12 bits and evenly spaced levels. The second is a low-precision scheme with 5 bits and logarithmically spaced levels.

A conversion starts with a single-cycle `start` pulse. On that pulse the block latches the scheme from `mode_log`. It then resolves one bit per clock, from the most significant bit down to the least. For each trial it presents two things: a trial code, and the reference level of that code in the selected reference bank. An external comparator returns `cmp_hi` in the same cycle. When the conversion ends, the block pulses `done` and holds the code on `result`.

The logarithmic bank uses a piecewise-linear approximation of the log curve. The upper bits of the code select a segment, and the segment sets both the base level and the step size. The lower bits select a point inside the segment.

The result leaves the block on a plain register with no back-pressure. A consumer must capture `result` at or after `done`. `result` stays valid until the next accepted `start`.

Top module: `sar_dualmode_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `bank_sel`, `trial_code`, `dac_level` and `result` are all zero.
- R2: A `start` pulse while idle latches `mode_log` (0 = linear, 1 = logarithmic) into `bank_sel`. While busy, `start` and changes to `mode_log` have no effect on the trial count or on the result.
- R3: In linear mode a conversion takes exactly 12 decision cycles. The first trial code is 2048. Each trial's `dac_level` equals its trial code.
- R4: In logarithmic mode a conversion takes exactly 5 decision cycles. For a code c, the segment s is c[4:2] and the offset o is c[1:0]. The reference level is 16*(2^s − 1) + o*4*2^s, so the first trial (code 16) has `dac_level` 240.
- R5: In logarithmic mode, `result` and `trial_code` are right-aligned, and bits 11:5 of each are zero.
- R6: `done` is high for exactly one cycle, in the cycle after the last decision edge. An accepted `start` clears `result` to zero, and `result` then holds the final code until the next accepted `start`.
- R7: While busy, `bank_sel` equals the latched mode and does not change.
- R8: A trial bit is kept when `cmp_hi` is 1, meaning the sample is at or above `dac_level`. The final code is therefore the largest code whose reference level does not exceed the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle request to begin a conversion; ignored while busy |
| mode_log | input | 1 | Scheme select: 0 = 12-bit linear, 1 = 5-bit logarithmic |
| cmp_hi | input | 1 | Comparator decision for the current trial (1 = sample ≥ level) |
| trial_code | output | 12 | Code under trial; zero when idle |
| dac_level | output | 12 | Reference level of the trial code in the selected bank |
| bank_sel | output | 1 | Reference bank in use (latched mode) |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when `result` becomes final |
| result | output | 12 | Final code, right-aligned |

## Verification
The bench sweeps every 12-bit sample value through both schemes. Its comparator model checks each final code against the largest code whose level fits the sample. A wrong segment base or step in the logarithmic bank would move the code boundaries, and a comparator-polarity error would give codes off by one level.

The bench also counts the cycles between start and done in each scheme. A bit-depth error would give 11 or 13 trials in place of 12, or a 12-trial run in place of 5.

Some conversions toggle `mode_log` and repeat `start` in the middle of a conversion. A design that followed the live input would switch banks or restart the conversion, and the result or the cycle count would go wrong. After each conversion the bench checks that `done` has fallen and that `result` has held its value, which catches a stretched pulse or an early clear.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    MODE_LIN = 1'b0,
    MODE_LOG = 1'b1
  } sar_mode_e;

  localparam int unsigned OUT_W_DEF    = 12;
  localparam int unsigned LIN_BITS_DEF = 12;
  localparam int unsigned LOG_BITS_DEF = 5;
  localparam int unsigned SEG_BITS_DEF = 3;
  localparam int unsigned STEP_SH_DEF  = 2;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int unsigned OUT_W    = OUT_W_DEF,
  parameter int unsigned LIN_BITS = LIN_BITS_DEF,
  parameter int unsigned LOG_BITS = LOG_BITS_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_log,
  input  logic             cmp_hi,
  output logic             busy,
  output logic             done,
  output sar_mode_e        mode_q,
  output logic [OUT_W-1:0] trial_code,
  output logic [OUT_W-1:0] result
);
  localparam int unsigned IDX_W = $clog2(OUT_W);
  localparam logic [IDX_W-1:0] LIN_TOP = IDX_W'(LIN_BITS - 1);
  localparam logic [IDX_W-1:0] LOG_TOP = IDX_W'(LOG_BITS - 1);
  localparam logic [OUT_W-1:0] ONE     = {{(OUT_W-1){1'b0}}, 1'b1};

  logic [IDX_W-1:0] idx;
  logic [OUT_W-1:0] acc;
  logic [OUT_W-1:0] decided;

  // Current trial: settled bits plus the bit under test.
  assign trial_code = busy ? (acc | (ONE << idx)) : '0;
  assign decided    = cmp_hi ? trial_code : acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      mode_q <= MODE_LIN;
      idx    <= '0;
      acc    <= '0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          mode_q <= sar_mode_e'(mode_log);
          idx    <= mode_log ? LOG_TOP : LIN_TOP;
          acc    <= '0;
          result <= '0;
        end
      end else begin
        acc <= decided;
        if (idx == '0) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= decided;
        end else begin
          idx <= idx - 1'b1;
        end
      end
    end
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));

  assert_mode_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(mode_q));

  assert_log_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == MODE_LOG) |-> (result >> LOG_BITS) == '0);
endmodule

// File: rtl/sar_lin_bank.sv
module sar_lin_bank #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned LVL_W  = 12
) (
  input  logic [CODE_W-1:0] code,
  output logic [LVL_W-1:0]  level
);
  // Evenly spaced levels: one level step per code step.
  assign level = LVL_W'(code);
endmodule

// File: rtl/sar_log_bank.sv
module sar_log_bank #(
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned SEG_BITS = 3,
  parameter int unsigned STEP_SH  = 2,
  parameter int unsigned LVL_W    = 12
) (
  input  logic [CODE_W-1:0] code,
  output logic [LVL_W-1:0]  level
);
  localparam int unsigned OFF_BITS = CODE_W - SEG_BITS;
  localparam logic [LVL_W-1:0] ONE = {{(LVL_W-1){1'b0}}, 1'b1};

  logic [SEG_BITS-1:0] seg;
  logic [OFF_BITS-1:0] off;
  logic [LVL_W-1:0]    seg_pow;
  logic [LVL_W-1:0]    base;
  logic [LVL_W-1:0]    span;

  assign seg     = code[CODE_W-1 -: SEG_BITS];
  assign off     = code[OFF_BITS-1:0];
  assign seg_pow = ONE << seg;
  // Segment start: sum of all earlier segment widths (geometric).
  assign base    = (seg_pow - ONE) << (OFF_BITS + STEP_SH);
  // Position inside the segment: step doubles each segment.
  assign span    = LVL_W'(off) << (32'(seg) + STEP_SH);
  assign level   = base + span;

  always_comb begin
    assert_log_mono_R4: assert (base <= level);
  end
endmodule

// File: rtl/sar_dualmode_ctrl.sv
module sar_dualmode_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned OUT_W    = OUT_W_DEF,
  parameter int unsigned LIN_BITS = LIN_BITS_DEF,
  parameter int unsigned LOG_BITS = LOG_BITS_DEF,
  parameter int unsigned SEG_BITS = SEG_BITS_DEF,
  parameter int unsigned STEP_SH  = STEP_SH_DEF,
  parameter int unsigned LVL_W    = OUT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_log,
  input  logic             cmp_hi,
  output logic [OUT_W-1:0] trial_code,
  output logic [LVL_W-1:0] dac_level,
  output logic             bank_sel,
  output logic             busy,
  output logic             done,
  output logic [OUT_W-1:0] result
);
  sar_mode_e      mode_q;
  logic [LVL_W-1:0] lvl_lin;
  logic [LVL_W-1:0] lvl_log;

  sar_seq #(.OUT_W(OUT_W), .LIN_BITS(LIN_BITS), .LOG_BITS(LOG_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_log(mode_log),
    .cmp_hi(cmp_hi), .busy(busy), .done(done), .mode_q(mode_q),
    .trial_code(trial_code), .result(result)
  );

  sar_lin_bank #(.CODE_W(OUT_W), .LVL_W(LVL_W)) u_lin (
    .code(trial_code), .level(lvl_lin)
  );

  sar_log_bank #(.CODE_W(LOG_BITS), .SEG_BITS(SEG_BITS), .STEP_SH(STEP_SH),
                 .LVL_W(LVL_W)) u_log (
    .code(trial_code[LOG_BITS-1:0]), .level(lvl_log)
  );

  assign bank_sel  = (mode_q == MODE_LOG);
  assign dac_level = !busy ? '0 : (bank_sel ? lvl_log : lvl_lin);

  assert_log_trial_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bank_sel) |-> (trial_code >> LOG_BITS) == '0);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (trial_code == '0 && dac_level == '0));
endmodule

// File: tb/sar_dualmode_ctrl_tb.sv
module sar_dualmode_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode_log = 1'b0;
  logic cmp_hi;
  logic [11:0] trial_code, dac_level, result;
  logic bank_sel, busy, done;
  int unsigned sample = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  // Behavioural comparator: sample at or above the presented level.
  assign cmp_hi = (sample >= int'(dac_level));

  sar_dualmode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_log(mode_log),
    .cmp_hi(cmp_hi), .trial_code(trial_code), .dac_level(dac_level),
    .bank_sel(bank_sel), .busy(busy), .done(done), .result(result)
  );

  function automatic int log_level(int c);
    int s = c / 4;
    int o = c % 4;
    return 16 * ((2 ** s) - 1) + o * 4 * (2 ** s);
  endfunction

  function automatic int exp_code(bit lg, int smp);
    int best = 0;
    if (!lg) return smp;
    for (int c = 0; c < 32; c++) if (log_level(c) <= smp) best = c;
    return best;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(bit lg, int smp, bit disturb, bit full);
    int n = 0;
    int exp;
    int hold;
    @(negedge clk);
    sample = smp; mode_log = lg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (full) begin
      chk(result == 0, "R6 clear at start", result, 0);
      chk(bank_sel == lg, "R7 bank select", bank_sel, lg);
      chk(trial_code == (lg ? 16 : 2048), "R3/R4 first trial code",
          trial_code, lg ? 16 : 2048);
      chk(dac_level == (lg ? 240 : 2048), "R3/R4 first trial level",
          dac_level, lg ? 240 : 2048);
    end
    while (!done && n < 40) begin
      if (disturb) begin
        mode_log = ~mode_log;
        start = n[0];
      end
      @(negedge clk);
      n++;
      if (disturb && busy) chk(bank_sel == lg, "R7 bank stable", bank_sel, lg);
    end
    start = 1'b0;
    exp = exp_code(lg, smp);
    chk(n == (lg ? 5 : 12), lg ? "R4 trial count" : "R3 trial count", n, lg ? 5 : 12);
    chk(result == exp, disturb ? "R2 ignored inputs" : "R8 final code", result, exp);
    if (lg) chk(result[11:5] == 0, "R5 upper bits", result[11:5], 0);
    if (full) begin
      hold = result;
      @(negedge clk);
      chk(!done, "R6 done one cycle", done, 0);
      chk(result == hold, "R6 result held", result, hold);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++; failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && result == 0 && trial_code == 0 && dac_level == 0 && !bank_sel,
        "R1 reset state", {busy, done, bank_sel}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && result == 0, "R1 idle after reset", busy, 0);

    convert(1'b0, 2048, 1'b0, 1'b1);
    convert(1'b1, 240, 1'b0, 1'b1);
    convert(1'b1, 239, 1'b0, 1'b1);
    convert(1'b1, 4095, 1'b0, 1'b1);
    convert(1'b0, 0, 1'b0, 1'b1);
    convert(1'b0, 4095, 1'b0, 1'b1);
    convert(1'b0, 1234, 1'b1, 1'b1);
    convert(1'b1, 1000, 1'b1, 1'b1);

    for (int s = 0; s < 4096; s++) convert(1'b0, s, 1'b0, 1'b0);
    for (int s = 0; s < 4096; s++) convert(1'b1, s, 1'b0, 1'b0);
    report();
  end
endmodule